// File: doc/BRIEF.md
# External Trigger Conditioner

This block turns an asynchronous external trigger into a clean start request for a conversion sequencer. One input is chosen from a set of dedicated trigger pins and the digital copies of the analog channels. The chosen signal is brought into the clock domain by a synchronizer and then qualified by a sensitivity mode. In the two edge modes the block emits a one-cycle start pulse for each qualifying edge. In the two level modes it holds a request for as long as the input stays at the active level.

Two control bits pick the mode: a level/edge bit and a polarity bit. An enable bit gates the whole function. Any change to the source select, the mode bits or the enable clears the edge history and mutes the output for a short settle window. A stale sample from the previous source or mode therefore cannot be read as a new trigger.

Top module: `ext_trig_cond`

## Requirements
- R1: With `lvl_mode`=0 and `pol_high`=0, each falling edge of the selected input gives exactly one cycle of `start_o`=1, and rising edges give nothing.
- R2: With `lvl_mode`=0 and `pol_high`=1, each rising edge of the selected input gives exactly one cycle of `start_o`=1, and falling edges give nothing.
- R3: With `lvl_mode`=1 and `pol_high`=0, `start_o` stays 1 for as long as the selected input is low.
- R4: With `lvl_mode`=1 and `pol_high`=1, `start_o` stays 1 for as long as the selected input is high.
- R5: While `trig_en`=0, `start_o` stays 0 whatever the trigger inputs do.
- R6: `src_sel` codes 0 to 3 pick `trig_pin[code]` and codes 4 to 11 pick `chan_dig[code-4]`. Codes 12 to 15 pick a constant low level. Inputs that are not selected have no effect.
- R7: Without a configuration change, a change on the selected input shows on `start_o` three clock edges later: two synchronizer stages plus the output register.
- R8: After a change of `src_sel`, `lvl_mode`, `pol_high` or `trig_en` is sampled at clock edge j, `start_o` is 0 after edges j, j+1 and j+2. No edge is ever detected from samples taken on both sides of the change.
- R9: While `rst_n` is low, and until the settle window after reset release has passed, `start_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trig_pin | input | 4 | Dedicated asynchronous trigger pins |
| chan_dig | input | 8 | Digital copies of the analog channel inputs |
| src_sel | input | 4 | Trigger source code |
| trig_en | input | 1 | Function enable |
| lvl_mode | input | 1 | 1 = level sensitive, 0 = edge sensitive |
| pol_high | input | 1 | 1 = rising edge or high level, 0 = falling edge or low level |
| start_o | output | 1 | Start pulse in edge modes, sustained request in level modes |

## Verification
The hardest case is a source switch from a pin that is low to a pin that is already high while the block is in rising-edge mode. A naive edge detector would report a rising edge there, although no pin has moved. The bench parks one pin high and another low and watches the pin that is low. It then switches the select alone and checks that no pulse appears in the following cycles. After that it checks that a real rising edge on the new pin still gives a pulse. A level-mode switch between two pins that are both active also checks that the request drops for the full settle window even though the input never goes inactive.

// File: rtl/etc_pkg.sv
package etc_pkg;

  typedef enum logic [1:0] {
    SENS_FALL = 2'b00,
    SENS_RISE = 2'b01,
    SENS_LOW  = 2'b10,
    SENS_HIGH = 2'b11
  } sens_e;

  function automatic logic sens_is_level(sens_e s);
    return s[1];
  endfunction

  function automatic logic sens_active_val(sens_e s);
    return s[0];
  endfunction

endpackage

// File: rtl/trig_src_mux.sv
module trig_src_mux #(
  parameter int N_PINS = 4,
  parameter int N_CHAN = 8,
  parameter int SELW   = 4
) (
  input  logic [N_PINS-1:0] pins,
  input  logic [N_CHAN-1:0] chans,
  input  logic [SELW-1:0]   sel,
  output logic              sel_o
);
  localparam int TOTAL = N_PINS + N_CHAN;
  localparam int SPAN  = 1 << SELW;

  logic [SPAN-1:0] cand;

  for (genvar i = 0; i < SPAN; i++) begin : g_cand
    if (i < N_PINS) begin : g_pin
      assign cand[i] = pins[i];
    end else if (i < TOTAL) begin : g_chan
      assign cand[i] = chans[i-N_PINS];
    end else begin : g_unused
      assign cand[i] = 1'b0;
    end
  end

  assign sel_o = cand[sel];
endmodule

// File: rtl/trig_sync_chain.sv
module trig_sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = {sr_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign q = sr_q[STAGES-1];
endmodule

// File: rtl/trig_qualifier.sv
module trig_qualifier
  import etc_pkg::*;
#(
  parameter int SELW      = 4,
  parameter int BLANK_CYC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            syn,
  input  logic            en,
  input  sens_e           sens,
  input  logic [SELW-1:0] sel,
  output logic            cfg_chg_o,
  output logic            hold_o,
  output logic            req_o
);
  localparam int CW  = $clog2(BLANK_CYC + 1);
  localparam int CFW = SELW + 3;

  logic [CFW-1:0] cfg_now, cfg_q;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           cnt_en;
  logic           prev_q, req_q, req_d;
  logic           chg, hold, hit, act;

  always_comb begin
    cfg_now = {sel, en, sens};
    chg     = (cfg_now != cfg_q);
    cnt_en  = chg || (cnt_q != '0);
    cnt_d   = chg ? CW'(BLANK_CYC) : (cnt_q - CW'(1));
    hold    = chg || (cnt_q != '0);
    act     = sens_active_val(sens);
    if (sens_is_level(sens)) hit = (syn == act);
    else                     hit = (syn == act) && (prev_q != syn);
    req_d   = en && !hold && hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      cnt_q  <= CW'(BLANK_CYC);
      prev_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      cfg_q  <= cfg_now;
      if (cnt_en) cnt_q <= cnt_d;
      prev_q <= syn;
      req_q  <= req_d;
    end
  end

  assign cfg_chg_o = chg;
  assign hold_o    = hold;
  assign req_o     = req_q;
endmodule

// File: rtl/ext_trig_cond.sv
module ext_trig_cond
  import etc_pkg::*;
#(
  parameter int N_PINS      = 4,
  parameter int N_CHAN      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int SELW       = $clog2(N_PINS + N_CHAN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] trig_pin,
  input  logic [N_CHAN-1:0] chan_dig,
  input  logic [SELW-1:0]   src_sel,
  input  logic              trig_en,
  input  logic              lvl_mode,
  input  logic              pol_high,
  output logic              start_o
);
  logic  rst_meta, rst_int_n;
  logic  mux_out, syn, cfg_chg, hold;
  sens_e sens;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta  <= 1'b0;
      rst_int_n <= 1'b0;
    end else begin
      rst_meta  <= 1'b1;
      rst_int_n <= rst_meta;
    end
  end

  assign sens = sens_e'({lvl_mode, pol_high});

  trig_src_mux #(.N_PINS(N_PINS), .N_CHAN(N_CHAN), .SELW(SELW)) u_mux (
    .pins  (trig_pin),
    .chans (chan_dig),
    .sel   (src_sel),
    .sel_o (mux_out)
  );

  trig_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     (mux_out),
    .q     (syn)
  );

  trig_qualifier #(.SELW(SELW), .BLANK_CYC(SYNC_STAGES)) u_qual (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .syn       (syn),
    .en        (trig_en),
    .sens      (sens),
    .sel       (src_sel),
    .cfg_chg_o (cfg_chg),
    .hold_o    (hold),
    .req_o     (start_o)
  );
endmodule

// File: rtl/etc_checker.sv
module etc_checker (
  input logic clk,
  input logic rst_n,
  input logic trig_en,
  input logic lvl_mode,
  input logic pol_high,
  input logic syn,
  input logic hold,
  input logic start_o
);
  AST_EDGE_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o && !lvl_mode) |=> !start_o); // R1
  AST_EDGE_PULSE_SINGLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o && !lvl_mode && pol_high) |=> !start_o); // R2
  AST_LEVEL_LOW_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_en && lvl_mode && !pol_high && !hold) |=> (start_o == !$past(syn))); // R3
  AST_LEVEL_HIGH_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_en && lvl_mode && pol_high && !hold) |=> (start_o == $past(syn))); // R4
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_en |=> !start_o); // R5
  AST_MUTE_AFTER_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !start_o); // R8
endmodule

bind ext_trig_cond etc_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .trig_en  (trig_en),
  .lvl_mode (lvl_mode),
  .pol_high (pol_high),
  .syn      (syn),
  .hold     (hold),
  .start_o  (start_o)
);

// File: tb/ext_trig_cond_test.sv
module ext_trig_cond_test;
  localparam int CLK_P = 10;

  logic       clk;
  logic       rst_n;
  logic [3:0] pins;
  logic [7:0] chans;
  logic [3:0] sel;
  logic       en, lvl, pol;
  logic       start_o;

  int compared   = 0;
  int mismatched = 0;
  bit done       = 0;

  typedef struct {
    int    exp;
    string tag;
  } item_t;
  item_t sb[$];

  ext_trig_cond uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig_pin (pins),
    .chan_dig (chans),
    .src_sel  (sel),
    .trig_en  (en),
    .lvl_mode (lvl),
    .pol_high (pol),
    .start_o  (start_o)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // driver: one expected output value per clock edge
  task automatic expect_n(int v, int n, string tag);
    for (int i = 0; i < n; i++) begin
      item_t it;
      @(posedge clk);
      #1;
      it.exp = v;
      it.tag = tag;
      sb.push_back(it);
    end
  endtask

  // monitor: compares the output after each edge at the falling edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      compared++;
      if (start_o !== it.exp[0]) begin
        mismatched++;
        $display("FAIL %s: start_o actual %b expected %0d at %0t", it.tag, start_o, it.exp, $time);
      end
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run hung, all requirements unchecked");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pins = '0; chans = '0; sel = 4'd0;
    en = 1'b1; lvl = 1'b0; pol = 1'b1;
    expect_n(0, 3, "R9 in reset");
    rst_n = 1'b1;
    expect_n(0, 8, "R9 after release");

    // rising edge mode, pin 0
    pins[0] = 1'b1;
    expect_n(0, 2, "R7 latency"); expect_n(1, 1, "R2 rise pulse"); expect_n(0, 3, "R2 single");
    pins[0] = 1'b0;
    expect_n(0, 5, "R2 fall ignored");

    // falling edge mode
    pol = 1'b0;
    expect_n(0, 5, "R8 mode change");
    pins[0] = 1'b1;
    expect_n(0, 5, "R1 rise ignored");
    pins[0] = 1'b0;
    expect_n(0, 2, "R7 latency"); expect_n(1, 1, "R1 fall pulse"); expect_n(0, 3, "R1 single");

    // high level mode
    lvl = 1'b1; pol = 1'b1;
    expect_n(0, 5, "R4 inactive");
    pins[0] = 1'b1;
    expect_n(0, 2, "R7 latency"); expect_n(1, 4, "R4 held");
    pins[0] = 1'b0;
    expect_n(1, 2, "R4 pipeline"); expect_n(0, 3, "R4 released");

    // low level mode: input already low, request after the mute window
    pol = 1'b0;
    expect_n(0, 3, "R8 mute"); expect_n(1, 4, "R3 held");
    pins[0] = 1'b1;
    expect_n(1, 2, "R3 pipeline"); expect_n(0, 3, "R3 released");

    // disabled: nothing gets through
    en = 1'b0; pins[0] = 1'b0;
    expect_n(0, 8, "R5 low level disabled");
    pins = 4'hF;
    expect_n(0, 3, "R5 toggle");
    pins = 4'h0;
    expect_n(0, 3, "R5 toggle");
    lvl = 1'b0; pol = 1'b1;
    expect_n(0, 3, "R5 edge disabled");
    pins[0] = 1'b1;
    expect_n(0, 5, "R5 rise disabled");
    pins[0] = 1'b0; en = 1'b1;
    expect_n(0, 5, "R8 enable");

    // source select: pin 2
    sel = 4'd2;
    expect_n(0, 5, "R8 select");
    pins = 4'b1011;
    expect_n(0, 5, "R6 other pins ignored");
    pins[2] = 1'b1;
    expect_n(0, 2, "R7 latency"); expect_n(1, 1, "R6 pin2 pulse"); expect_n(0, 2, "R6 single");

    // channel 5 = code 9
    sel = 4'd9;
    expect_n(0, 5, "R8 select");
    chans[4] = 1'b1;
    expect_n(0, 5, "R6 other channel ignored");
    chans[5] = 1'b1;
    expect_n(0, 2, "R7 latency"); expect_n(1, 1, "R6 chan5 pulse"); expect_n(0, 2, "R6 single");

    // unused code reads as constant low
    sel = 4'd13; lvl = 1'b1; pol = 1'b0;
    expect_n(0, 3, "R8 mute"); expect_n(1, 3, "R6 unused code low");
    pins = 4'hF; chans = 8'hFF;
    expect_n(1, 4, "R6 unused code steady");

    // no false edge across a source switch
    lvl = 1'b0; pol = 1'b1; sel = 4'd1; pins = 4'b0001; chans = '0;
    expect_n(0, 6, "R8 quiet pin1");
    sel = 4'd0;
    expect_n(0, 8, "R8 no false edge");
    pins[0] = 1'b0;
    expect_n(0, 5, "R2 fall ignored");
    pins[0] = 1'b1;
    expect_n(0, 2, "R7 latency"); expect_n(1, 1, "R8 real edge after switch"); expect_n(0, 2, "R2 single");

    // level request drops across a switch between two active pins
    lvl = 1'b1;
    expect_n(0, 3, "R8 mute"); expect_n(1, 3, "R4 held");
    pins = 4'b1001; sel = 4'd3;
    expect_n(0, 3, "R8 mute on switch"); expect_n(1, 3, "R4 new source");

    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule